// File: doc/BRIEF.md
# Predicated Vector Branch-Condition Evaluator

This block decides a vectorised conditional branch. After a start pulse it walks a vector of 4-bit condition fields in ascending element order, one element per clock. For each element it tests one bit of the field against two branch-option bits and folds the outcome into a running result. In all-mode every tested element must pass. In any-mode one passing element is enough. The walk stops as soon as the outcome is settled, so fields past the exit point are never read.

A predicate mask sets which elements take part. A masked-out element is either skipped completely, or, when zeroing is on, tested against a substitute bit instead of the field. An optional vector-length-set mode ends the walk at the first element whose result matches a chosen sense and reports a truncated length. When the walk ends, a one-cycle done pulse returns four values: the branch decision, the new length, the number of predicate-enabled elements consumed (used as the count-register decrement), and a link-write enable.

Condition fields come from an external 128-entry array through one combinational read port. The block drives the address and takes the 4-bit field back in the same cycle.

Top module: `vbr_eval`

## Requirements
- R1: After reset, busy, done, taken, vl_valid, vl_new, ctr_dec and link_en are all 0.
- R2: The base field number is {bit_sel[4:2], field_ext[3:0]}. When sel_vector=1, element i reads field (base+i) mod 128. When sel_vector=0, every element reads the base field. Bit n of the field is cr_rdata[n], and bit_sel[1:0] gives n.
- R3: The result of a tested element is opt_uncond OR NOT(testbit XOR opt_sense).
- R4: With mode_all=1 the result starts at 1, is ANDed with each tested element, and the walk stops at the first failing element. With mode_all=0 the result starts at 0, is ORed with each tested element, and the walk stops at the first passing element. At done, taken equals this result.
- R5: An element with predicate bit 0 while zero_en=0 is skipped. It does not change the result, it is not counted, and it does not stop the walk.
- R6: An element with predicate bit 0 while zero_en=1 uses subst_val as its test bit and can stop the walk. It is not counted in ctr_dec.
- R7: With vlset_en=1 the walk stops at the first tested element whose result equals trunc_sense. At done, vl_valid=1 and vl_new is that element's index plus vl_incl. In every other case vl_valid=0 and vl_new equals vec_len.
- R8: ctr_dec equals the number of predicate-1 elements processed up to and including the exit element.
- R9: With sel_vector=0 the walk stops after the first tested element, counting any element with predicate 0 that is tested by substitution.
- R10: vec_len=0 produces done in the cycle after start, with busy never high, taken=mode_all, ctr_dec=0 and vl_new=0.
- R11: Each walk cycle handles one element, and busy is high for one cycle per element visited, skipped elements included. The exit element is the last one visited. Done rises in the cycle after the last busy cycle.
- R12: A start pulse while busy is ignored. It changes neither the running result nor the outputs, and it adds no done pulse.
- R13: link_en = link_req AND (NOT link_only_taken OR taken). It is valid together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation when idle |
| vec_len | input | 7 | Vector length, 0..64 |
| pred_mask | input | 64 | Predicate bit per element |
| bit_sel | input | 5 | High three bits: base field high part; low two bits: bit in field |
| field_ext | input | 4 | Low four bits of the base field number |
| sel_vector | input | 1 | 1: field advances per element; 0: scalar field |
| opt_uncond | input | 1 | Branch option forcing every element to pass |
| opt_sense | input | 1 | Bit value that counts as a pass |
| mode_all | input | 1 | 1: all must pass; 0: any passes |
| zero_en | input | 1 | Substitute masked-out elements instead of skipping |
| subst_val | input | 1 | Bit substituted for masked-out elements |
| vlset_en | input | 1 | Enable length truncation |
| trunc_sense | input | 1 | Element result value that truncates |
| vl_incl | input | 1 | Include the truncating element in the new length |
| link_req | input | 1 | Link register write requested |
| link_only_taken | input | 1 | Restrict link write to taken branches |
| cr_raddr | output | 7 | Condition field read address |
| cr_rdata | input | 4 | Condition field read data (same cycle) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch decision |
| vl_valid | output | 1 | Length was truncated |
| vl_new | output | 7 | Resulting vector length |
| ctr_dec | output | 7 | Count-register decrement |
| link_en | output | 1 | Link register write enable |

## Verification
The hardest case to reach is an exit on an element whose predicate bit is 0. Zeroing must be on, and the substitute bit must make that element decide the walk, while the field behind it would have given the opposite answer. The bench builds this case with the same field contents twice, changing only subst_val. That shows a masked element can end the walk without adding to the decrement. Early exit is confirmed by counting busy cycles, which rules out reads past the exit element. A second start issued mid-walk shows that it leaves the results unchanged and adds no pulse.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_e;

  typedef struct packed {
    logic is_vector;
    logic opt_uncond;
    logic opt_sense;
    logic mode_all;
    logic zero_en;
    logic subst_val;
    logic vlset_en;
    logic trunc_sense;
    logic vl_incl;
    logic link_req;
    logic link_only;
  } walk_cfg_t;

endpackage

// File: rtl/vbr_elem_test.sv
module vbr_elem_test #(
  parameter int FIELD_W = 4,
  localparam int POS_W = $clog2(FIELD_W)
) (
  input  logic               pred_bit,
  input  logic               zero_en,
  input  logic               subst_val,
  input  logic [FIELD_W-1:0] field,
  input  logic [POS_W-1:0]   bit_pos,
  input  logic               opt_uncond,
  input  logic               opt_sense,
  output logic               tested,
  output logic               counted,
  output logic               result
);

  logic test_bit;

  always_comb begin
    tested   = pred_bit | zero_en;
    counted  = pred_bit;
    test_bit = pred_bit ? field[bit_pos] : subst_val;
    result   = opt_uncond | ~(test_bit ^ opt_sense);
  end

endmodule

// File: rtl/vbr_exit_ctl.sv
module vbr_exit_ctl #(
  parameter int LEN_W = 7
) (
  input  logic             tested,
  input  logic             result,
  input  logic             mode_all,
  input  logic             is_vector,
  input  logic             vlset_en,
  input  logic             trunc_sense,
  input  logic             vl_incl,
  input  logic             last_elem,
  input  logic [LEN_W-1:0] idx,
  output logic             stop,
  output logic             vl_hit,
  output logic [LEN_W-1:0] vl_trunc
);

  logic settled;

  always_comb begin
    vl_hit   = tested & vlset_en & (result == trunc_sense);
    settled  = mode_all ? ~result : result;
    stop     = last_elem | (tested & (vl_hit | settled | ~is_vector));
    vl_trunc = idx + {{(LEN_W-1){1'b0}}, vl_incl};
  end

endmodule

// File: rtl/vbr_eval.sv
module vbr_eval
  import vbr_pkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int NUM_FIELDS = 128,
  parameter int FIELD_W    = 4,
  parameter int HI_W       = 3,
  localparam int POS_W  = $clog2(FIELD_W),
  localparam int SEL_W  = HI_W + POS_W,
  localparam int ADDR_W = $clog2(NUM_FIELDS),
  localparam int EXT_W  = ADDR_W - HI_W,
  localparam int LEN_W  = $clog2(MAX_VL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LEN_W-1:0]   vec_len,
  input  logic [MAX_VL-1:0]  pred_mask,
  input  logic [SEL_W-1:0]   bit_sel,
  input  logic [EXT_W-1:0]   field_ext,
  input  logic               sel_vector,
  input  logic               opt_uncond,
  input  logic               opt_sense,
  input  logic               mode_all,
  input  logic               zero_en,
  input  logic               subst_val,
  input  logic               vlset_en,
  input  logic               trunc_sense,
  input  logic               vl_incl,
  input  logic               link_req,
  input  logic               link_only_taken,
  output logic [ADDR_W-1:0]  cr_raddr,
  input  logic [FIELD_W-1:0] cr_rdata,
  output logic               busy,
  output logic               done,
  output logic               taken,
  output logic               vl_valid,
  output logic [LEN_W-1:0]   vl_new,
  output logic [LEN_W-1:0]   ctr_dec,
  output logic               link_en
);

  // walk state
  walk_st_e           state_q, state_d;
  logic [LEN_W-1:0]   idx_q, idx_d;
  logic               acc_q, acc_d;
  logic [LEN_W-1:0]   cnt_q, cnt_d;
  // captured command
  logic [LEN_W-1:0]   len_q;
  logic [MAX_VL-1:0]  mask_q;
  logic [ADDR_W-1:0]  base_q;
  logic [POS_W-1:0]   pos_q;
  walk_cfg_t          cfg_q, cfg_in;
  // results
  logic               done_q, done_d;
  logic               taken_q, taken_d;
  logic               vlv_q, vlv_d;
  logic [LEN_W-1:0]   vln_q, vln_d;
  logic [LEN_W-1:0]   dec_q, dec_d;
  logic               link_q, link_d;

  logic               cap_en;
  logic               walk_en;
  logic [MAX_VL-1:0]  mask_sh;
  logic               pred_bit;
  logic               last_elem;
  logic               el_tested, el_counted, el_result;
  logic               el_stop, el_vl_hit;
  logic [LEN_W-1:0]   el_vl_trunc;
  logic               acc_nx;
  logic [LEN_W-1:0]   cnt_nx;

  always_comb begin
    cfg_in.is_vector   = sel_vector;
    cfg_in.opt_uncond  = opt_uncond;
    cfg_in.opt_sense   = opt_sense;
    cfg_in.mode_all    = mode_all;
    cfg_in.zero_en     = zero_en;
    cfg_in.subst_val   = subst_val;
    cfg_in.vlset_en    = vlset_en;
    cfg_in.trunc_sense = trunc_sense;
    cfg_in.vl_incl     = vl_incl;
    cfg_in.link_req    = link_req;
    cfg_in.link_only   = link_only_taken;
  end

  // element addressing and predicate pick
  always_comb begin
    mask_sh   = mask_q >> idx_q;
    pred_bit  = mask_sh[0];
    cr_raddr  = cfg_q.is_vector ? (base_q + ADDR_W'(idx_q)) : base_q;
    last_elem = (idx_q == (len_q - LEN_W'(1)));
  end

  vbr_elem_test #(.FIELD_W(FIELD_W)) u_elem (
    .pred_bit   (pred_bit),
    .zero_en    (cfg_q.zero_en),
    .subst_val  (cfg_q.subst_val),
    .field      (cr_rdata),
    .bit_pos    (pos_q),
    .opt_uncond (cfg_q.opt_uncond),
    .opt_sense  (cfg_q.opt_sense),
    .tested     (el_tested),
    .counted    (el_counted),
    .result     (el_result)
  );

  vbr_exit_ctl #(.LEN_W(LEN_W)) u_exit (
    .tested      (el_tested),
    .result      (el_result),
    .mode_all    (cfg_q.mode_all),
    .is_vector   (cfg_q.is_vector),
    .vlset_en    (cfg_q.vlset_en),
    .trunc_sense (cfg_q.trunc_sense),
    .vl_incl     (cfg_q.vl_incl),
    .last_elem   (last_elem),
    .idx         (idx_q),
    .stop        (el_stop),
    .vl_hit      (el_vl_hit),
    .vl_trunc    (el_vl_trunc)
  );

  // reduction of this element into the running result
  always_comb begin
    acc_nx = acc_q;
    if (el_tested) begin
      acc_nx = cfg_q.mode_all ? (acc_q & el_result) : (acc_q | el_result);
    end
    cnt_nx = cnt_q + {{(LEN_W-1){1'b0}}, el_counted};
  end

  // next-state logic
  always_comb begin
    cap_en  = (state_q == ST_IDLE) && start;
    walk_en = (state_q == ST_WALK);
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    taken_d = taken_q;
    vlv_d   = vlv_q;
    vln_d   = vln_q;
    dec_d   = dec_q;
    link_d  = link_q;
    if (cap_en) begin
      idx_d = '0;
      acc_d = mode_all;
      cnt_d = '0;
      if (vec_len == '0) begin
        done_d  = 1'b1;
        taken_d = mode_all;
        vlv_d   = 1'b0;
        vln_d   = '0;
        dec_d   = '0;
        link_d  = link_req & (~link_only_taken | mode_all);
      end else begin
        state_d = ST_WALK;
      end
    end else if (walk_en) begin
      acc_d = acc_nx;
      cnt_d = cnt_nx;
      idx_d = idx_q + LEN_W'(1);
      if (el_stop) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        taken_d = acc_nx;
        vlv_d   = el_vl_hit;
        vln_d   = el_vl_hit ? el_vl_trunc : len_q;
        dec_d   = cnt_nx;
        link_d  = cfg_q.link_req & (~cfg_q.link_only | acc_nx);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acc_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= '0;
      mask_q  <= '0;
      base_q  <= '0;
      pos_q   <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
      taken_q <= 1'b0;
      vlv_q   <= 1'b0;
      vln_q   <= '0;
      dec_q   <= '0;
      link_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cap_en) begin
        len_q  <= vec_len;
        mask_q <= pred_mask;
        base_q <= {bit_sel[SEL_W-1:POS_W], field_ext};
        pos_q  <= bit_sel[POS_W-1:0];
        cfg_q  <= cfg_in;
      end
      if (cap_en || walk_en) begin
        idx_q <= idx_d;
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
      if (done_d) begin
        taken_q <= taken_d;
        vlv_q   <= vlv_d;
        vln_q   <= vln_d;
        dec_q   <= dec_d;
        link_q  <= link_d;
      end
    end
  end

  assign busy     = (state_q == ST_WALK);
  assign done     = done_q;
  assign taken    = taken_q;
  assign vl_valid = vlv_q;
  assign vl_new   = vln_q;
  assign ctr_dec  = dec_q;
  assign link_en  = link_q;

  // a masked element that is skipped leaves result and count alone (R5)
  assert_skip_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_en && !pred_bit && !cfg_q.zero_en && !el_stop)
      |=> (acc_q == $past(acc_q)) && (cnt_q == $past(cnt_q)));

  // walk index never passes the captured length (R11)
  assert_idx_in_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx_q < len_q));

  // done is never raised while the walk is still running (R11)
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // decrement cannot exceed the vector length (R8)
  assert_dec_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctr_dec <= len_q));

  // truncated length stays within the original length plus nothing (R7)
  assert_trunc_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vl_valid) |-> (vl_new <= len_q));

  // a start during a walk leaves the captured command unchanged (R12)
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(len_q) && $stable(mask_q) && $stable(cfg_q)));

  // restricted link write only on a taken branch (R13)
  assert_link_taken_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done && link_en && cfg_q.link_only) |-> taken);

endmodule

// File: tb/vbr_eval_tb.sv
module vbr_eval_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [6:0]  vec_len;
  logic [63:0] pred_mask;
  logic [4:0]  bit_sel;
  logic [3:0]  field_ext;
  logic        sel_vector, opt_uncond, opt_sense, mode_all, zero_en, subst_val;
  logic        vlset_en, trunc_sense, vl_incl, link_req, link_only_taken;
  logic [6:0]  cr_raddr;
  logic [3:0]  cr_rdata;
  logic        busy, done, taken, vl_valid, link_en;
  logic [6:0]  vl_new, ctr_dec;

  logic [3:0]  cr_mem [128];
  assign cr_rdata = cr_mem[cr_raddr];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  vbr_eval u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .pred_mask(pred_mask), .bit_sel(bit_sel), .field_ext(field_ext),
    .sel_vector(sel_vector), .opt_uncond(opt_uncond), .opt_sense(opt_sense),
    .mode_all(mode_all), .zero_en(zero_en), .subst_val(subst_val),
    .vlset_en(vlset_en), .trunc_sense(trunc_sense), .vl_incl(vl_incl),
    .link_req(link_req), .link_only_taken(link_only_taken),
    .cr_raddr(cr_raddr), .cr_rdata(cr_rdata), .busy(busy), .done(done),
    .taken(taken), .vl_valid(vl_valid), .vl_new(vl_new), .ctr_dec(ctr_dec),
    .link_en(link_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  task automatic fill_mem(input logic [3:0] v);
    for (int i = 0; i < 128; i++) cr_mem[i] = v;
  endtask

  task automatic defaults();
    start = 0; vec_len = 0; pred_mask = '1; bit_sel = 5'b010_01; field_ext = 4'd3;
    sel_vector = 1; opt_uncond = 0; opt_sense = 1; mode_all = 0; zero_en = 0;
    subst_val = 0; vlset_en = 0; trunc_sense = 0; vl_incl = 0; link_req = 0;
    link_only_taken = 0;
    fill_mem(4'b0000);
  endtask

  function automatic int base_field();
    return {bit_sel[4:2], field_ext};
  endfunction

  // reference model built from the requirement list
  task automatic model(output int e_taken, output int e_vlv, output int e_vln,
                       output int e_dec, output int e_link, output int e_cyc);
    int  b;
    bit  acc, tb, r, p;
    b = base_field();
    acc = mode_all; e_dec = 0; e_cyc = 0; e_vlv = 0; e_vln = vec_len;
    for (int i = 0; i < vec_len; i++) begin
      e_cyc = i + 1;
      p = pred_mask[i];
      if (!p && !zero_en) continue;
      if (p) tb = cr_mem[sel_vector ? ((b + i) % 128) : b][bit_sel[1:0]];
      else   tb = subst_val;
      r = opt_uncond | ~(tb ^ opt_sense);
      acc = mode_all ? (acc & r) : (acc | r);
      if (p) e_dec++;
      if (vlset_en && (r == trunc_sense)) begin
        e_vlv = 1; e_vln = i + vl_incl;
        break;
      end
      if (mode_all ? !r : r) break;
      if (!sel_vector) break;
    end
    e_taken = acc;
    e_link = link_req & (!link_only_taken | acc);
  endtask

  task automatic run_check(input string req, input bit interfere = 0);
    int e_taken, e_vlv, e_vln, e_dec, e_link, e_cyc;
    int cyc, guard, extra;
    model(e_taken, e_vlv, e_vln, e_dec, e_link, e_cyc);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 0; guard = 0;
    while (!done && guard < 300) begin
      if (busy) cyc++;
      if (interfere && cyc == 2) begin
        start = 1; vec_len = 7'd3; mode_all = ~mode_all; opt_uncond = 1;
      end else begin
        start = 0;
      end
      @(negedge clk);
      guard++;
    end
    start = 0;
    check(req, "done seen", int'(done), 1);
    check(req, "taken", int'(taken), e_taken);
    check(req, "vl_valid", int'(vl_valid), e_vlv);
    check(req, "vl_new", int'(vl_new), e_vln);
    check(req, "ctr_dec", int'(ctr_dec), e_dec);
    check(req, "link_en", int'(link_en), e_link);
    check(req, "busy cycles", cyc, e_cyc);
    if (interfere) begin
      extra = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done || busy) extra++;
      end
      check("R12", "activity after ignored start", extra, 0);
    end
  endtask

  task automatic t_reset_R1();
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "taken", int'(taken), 0);
    check("R1", "vl_new", int'(vl_new), 0);
    check("R1", "ctr_dec", int'(ctr_dec), 0);
    check("R1", "link_en", int'(link_en), 0);
  endtask

  task automatic t_any_R4();
    defaults(); vec_len = 10; cr_mem[35 + 5] = 4'b0010;
    run_check("R4_any");   // exits at element 5, taken 1
    defaults(); vec_len = 10;
    run_check("R4_any_none");
  endtask

  task automatic t_all_R4();
    defaults(); mode_all = 1; vec_len = 12; fill_mem(4'b0010); cr_mem[35 + 3] = 4'b1101;
    run_check("R4_all_fail");  // stops at element 3
    defaults(); mode_all = 1; vec_len = 64; fill_mem(4'b0010);
    run_check("R8_full_len"); // all 64 counted
  endtask

  task automatic t_skip_R5();
    defaults(); vec_len = 12; pred_mask = ~64'h30;
    cr_mem[35 + 4] = 4'b0010; cr_mem[35 + 5] = 4'b0010; cr_mem[35 + 9] = 4'b0010;
    run_check("R5_skip");      // exits at 9, decrement 8
  endtask

  task automatic t_zero_R6();
    defaults(); mode_all = 1; zero_en = 1; subst_val = 1; vec_len = 8;
    fill_mem(4'b0010); cr_mem[35 + 2] = 4'b0000; cr_mem[35 + 3] = 4'b0000;
    pred_mask = ~64'h0C;
    run_check("R6_subst_one"); // passes, decrement 6
    subst_val = 0;
    run_check("R6_subst_zero"); // fails at masked element 2, decrement 2
  endtask

  task automatic t_vlset_R7();
    defaults(); vlset_en = 1; trunc_sense = 1; vl_incl = 1; vec_len = 9;
    cr_mem[35 + 4] = 4'b0010;
    run_check("R7_incl");      // vl_new 5
    defaults(); mode_all = 1; vlset_en = 1; trunc_sense = 0; vec_len = 9;
    fill_mem(4'b0010); cr_mem[35 + 6] = 4'b0000;
    run_check("R7_excl");      // vl_new 6
    defaults(); vlset_en = 1; trunc_sense = 0; vec_len = 9;
    run_check("R7_first");     // vl_new 0
  endtask

  task automatic t_scalar_R9();
    defaults(); sel_vector = 0; vec_len = 8; pred_mask = ~64'h7;
    cr_mem[35] = 4'b0010;
    run_check("R9_scalar_any");
    defaults(); sel_vector = 0; mode_all = 1; vec_len = 8; cr_mem[35] = 4'b0010;
    cr_mem[36] = 4'b0000;
    run_check("R9_scalar_all");
    defaults(); sel_vector = 0; zero_en = 1; subst_val = 1; vec_len = 8;
    pred_mask = ~64'h1;
    run_check("R9_scalar_subst");
  endtask

  task automatic t_len0_R10();
    defaults(); vec_len = 0;
    run_check("R10_any");
    mode_all = 1;
    run_check("R10_all");
  endtask

  task automatic t_uncond_R3();
    defaults(); opt_uncond = 1; vec_len = 6;
    run_check("R3_uncond");
    defaults(); opt_sense = 0; bit_sel = 5'b010_11; vec_len = 6;
    fill_mem(4'b1000); cr_mem[35 + 2] = 4'b0111;
    run_check("R3_sense0");    // bit 3 zero at element 2 passes
  endtask

  task automatic t_addr_R2();
    defaults(); mode_all = 1; bit_sel = 5'b111_00; field_ext = 4'hF; vec_len = 4;
    fill_mem(4'b0000); cr_mem[127] = 4'b0001; cr_mem[0] = 4'b0001;
    cr_mem[1] = 4'b0001; cr_mem[2] = 4'b0001;
    run_check("R2_wrap_pass");
    cr_mem[1] = 4'b1110;
    run_check("R2_wrap_fail"); // stops at element 2 (field 1)
  endtask

  task automatic t_link_R13();
    defaults(); vec_len = 4; link_req = 1; link_only_taken = 1;
    run_check("R13_not_taken");
    cr_mem[35 + 1] = 4'b0010;
    run_check("R13_taken");
    defaults(); vec_len = 4; link_req = 1; link_only_taken = 0;
    run_check("R13_always");
  endtask

  task automatic t_busy_R12();
    defaults(); mode_all = 1; vec_len = 10; fill_mem(4'b0010); cr_mem[35 + 7] = 4'b0000;
    run_check("R12_busy_start", 1);
  endtask

  initial begin
    defaults();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset_R1();
    rst_n = 1;
    @(negedge clk);
    t_reset_R1();
    t_any_R4();
    t_all_R4();
    t_skip_R5();
    t_zero_R6();
    t_vlset_R7();
    t_scalar_R9();
    t_len0_R10();
    t_uncond_R3();
    t_addr_R2();
    t_link_R13();
    t_busy_R12();   // busy-cycle counts above also cover R11
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule